// File: doc/BRIEF.md
# CCK Largest-Correlation Symbol Decision

This block turns the outputs of a complex correlator bank into data bits for a CCK receiver. It takes the correlator results one per cycle, each as a signed in-phase and quadrature pair. Over both channels it finds the single value with the largest magnitude and notes that value's correlator index, its channel and its sign. The channel and the sign give a phase quadrant. The modulo-4 difference between that quadrant and the previous symbol's quadrant gives two differential phase bits. The phase bits and the winning index together form one symbol word. The word is four bits wide in the short mode and eight bits wide in the long mode.

Before the first data symbol, the phase reference is seeded from the last demodulated bit of the preceding DBPSK header. The symbol word then leaves the block LSB first over a serial valid/ready port, on its way to a descrambler. While bits of a symbol are still pending, the block accepts no new correlator values, so the next decision waits until the current word has been shifted out.

Top module: `cck_pick_top`

## Requirements
- R1: After reset, `outValid` is 0, `inReady` is 1 and the phase reference is quadrant 0.
- R2: A symbol's winner is the in-phase or quadrature value with the largest absolute value among all correlator pairs accepted for that symbol, including a value of -2048.
- R3: Ties keep the lowest correlator index. Within one index, the in-phase value wins over an equal quadrature value.
- R4: The winner maps to a quadrant as follows: in-phase and non-negative gives 0, quadrature and non-negative gives 1, in-phase and negative gives 2, quadrature and negative gives 3.
- R5: The phase bits are (winner quadrant − reference) mod 4. The reference then becomes the winner quadrant.
- R6: `seedValid` sets the reference to 0 when `seedBit` is 0 and to 2 when `seedBit` is 1. If the seed arrives in the same cycle as a symbol's final correlator, that symbol uses the old reference and the seed becomes the reference for the following symbol.
- R7: The symbol word has the phase bits in bits [1:0] and the winning index above them. In short mode (`longMode`=0) there are 4 correlators per symbol, a 2-bit index and a 4-bit word. In long mode (`longMode`=1) there are 64 correlators, a 6-bit index and an 8-bit word.
- R8: The word is sent LSB first, one bit for each cycle in which `outValid` and `outReady` are both high. `outValid` drops after the last bit.
- R9: While `outValid` is high and `outReady` is low, `outValid` stays high and `outBit` stays unchanged.
- R10: `inReady` is 0 while bits are pending. Correlator values and `inLast` offered while `inReady` is 0 are ignored, and the next symbol starts again at index 0.
- R11: A symbol closes on an accepted `inLast` or on its mode's final correlator index, whichever comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| longMode | input | 1 | 0: 4 correlators, 4-bit word; 1: 64 correlators, 8-bit word |
| inValid | input | 1 | Correlator pair offered |
| inLast | input | 1 | Offered pair is the symbol's last |
| inI | input | 12 | Signed in-phase correlation |
| inQ | input | 12 | Signed quadrature correlation |
| inReady | output | 1 | Block accepts a correlator pair |
| seedValid | input | 1 | Load phase reference from header bit |
| seedBit | input | 1 | Last demodulated header bit |
| outValid | output | 1 | Serial bit available |
| outBit | output | 1 | Serial data bit, LSB of word first |
| outReady | input | 1 | Downstream takes the bit |

## Verification
Two functions can fall in the same cycle: a symbol's decision, which both reads and rewrites the phase reference, and the loading of a new reference from the header seed. The bench drives `seedValid` together with the final correlator of a symbol. It then judges that symbol's phase bits against the old reference and the following symbol's phase bits against the seeded quadrant. The serial drain is also stalled irregularly, while rejected correlator values are offered in the same cycles, so that holding the word and ignoring input are checked together.

// File: rtl/cck_pick_pkg.sv
package cck_pick_pkg;
  typedef struct packed {
    logic take;    // pair accepted this cycle
    logic first;   // accepted pair is index 0
    logic finish;  // accepted pair closes the symbol
    logic shift;   // serial bit consumed
  } stepStrobes_t;

  typedef logic [1:0] quad_t;
endpackage

// File: rtl/cck_pick_ctrl.sv
module cck_pick_ctrl
  import cck_pick_pkg::*;
#(
  parameter int SHORT_CORR = 4,
  parameter int LONG_CORR  = 64,
  parameter int IDX_W      = $clog2(LONG_CORR),
  parameter int SHORT_W    = 2 + $clog2(SHORT_CORR),
  parameter int WORD_W     = 2 + IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             longMode,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic [IDX_W-1:0] idxCnt,
  output stepStrobes_t     strobes
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [IDX_W-1:0] SHORT_LASTIDX = IDX_W'(SHORT_CORR - 1);
  localparam logic [IDX_W-1:0] LONG_LASTIDX  = IDX_W'(LONG_CORR - 1);

  logic             busy;
  logic [CNT_W-1:0] bitsLeft;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx  = longMode ? LONG_LASTIDX : SHORT_LASTIDX;
  assign inReady  = !busy;
  assign outValid = busy;

  always_comb begin
    strobes.take   = inValid && !busy;
    strobes.first  = strobes.take && (idxCnt == '0);
    strobes.finish = strobes.take && (inLast || idxCnt == lastIdx);
    strobes.shift  = busy && outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
      idxCnt   <= '0;
    end else begin
      if (strobes.finish) begin
        idxCnt   <= '0;
        busy     <= 1'b1;
        bitsLeft <= longMode ? CNT_W'(WORD_W) : CNT_W'(SHORT_W);
      end else if (strobes.take) begin
        idxCnt <= idxCnt + 1'b1;
      end
      if (strobes.shift) begin
        bitsLeft <= bitsLeft - 1'b1;
        if (bitsLeft == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end

  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    idxCnt <= lastIdx || !strobes.take); // R11
  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady)); // R8
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R10
endmodule

// File: rtl/cck_pick_dp.sv
module cck_pick_dp
  import cck_pick_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int SHORT_CORR = 4,
  parameter int LONG_CORR  = 64,
  parameter int IDX_W      = $clog2(LONG_CORR),
  parameter int WORD_W     = 2 + IDX_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     longMode,
  input  stepStrobes_t             strobes,
  input  logic [IDX_W-1:0]         idxCnt,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     seedValid,
  input  logic                     seedBit,
  output logic                     outBit
);
  localparam int SIDX_W = $clog2(SHORT_CORR);

  function automatic logic [DATA_W-1:0] magOf(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? (~v + 1'b1) : v;
  endfunction

  logic [DATA_W-1:0] magI, magQ, curMag, bestMag, winMag;
  logic              curIsQ, curNeg, bestIsQ, bestNeg, winIsQ, winNeg, beats;
  logic [IDX_W-1:0]  bestIdx, winIdx;
  quad_t             winQuad, phaseRef, dPhase;
  logic [WORD_W-1:0] word, shReg;

  always_comb begin
    magI   = magOf(inI);
    magQ   = magOf(inQ);
    curIsQ = magQ > magI;
    curMag = curIsQ ? magQ : magI;
    curNeg = curIsQ ? inQ[DATA_W-1] : inI[DATA_W-1];
    beats  = strobes.first || (curMag > bestMag);
    winMag = beats ? curMag : bestMag;
    winIdx = beats ? idxCnt : bestIdx;
    winIsQ = beats ? curIsQ : bestIsQ;
    winNeg = beats ? curNeg : bestNeg;
    winQuad = {winNeg, winIsQ};
    dPhase  = winQuad - phaseRef;
    if (longMode) word = {winIdx, dPhase};
    else          word = WORD_W'({winIdx[SIDX_W-1:0], dPhase});
  end

  assign outBit = shReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestMag  <= '0;
      bestIdx  <= '0;
      bestIsQ  <= 1'b0;
      bestNeg  <= 1'b0;
      phaseRef <= '0;
      shReg    <= '0;
    end else begin
      if (strobes.take) begin
        bestMag <= winMag;
        bestIdx <= winIdx;
        bestIsQ <= winIsQ;
        bestNeg <= winNeg;
      end
      if (strobes.finish) begin
        shReg    <= word;
        phaseRef <= winQuad;
      end else if (strobes.shift) begin
        shReg <= shReg >> 1;
      end
      if (seedValid) phaseRef <= {seedBit, 1'b0};
    end
  end

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    seedValid |=> phaseRef == {$past(seedBit), 1'b0}); // R6
  AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && !strobes.first) |=> bestMag >= $past(bestMag)); // R2
endmodule

// File: rtl/cck_pick_top.sv
module cck_pick_top
  import cck_pick_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int SHORT_CORR = 4,
  parameter int LONG_CORR  = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     longMode,
  input  logic                     inValid,
  input  logic                     inLast,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     inReady,
  input  logic                     seedValid,
  input  logic                     seedBit,
  output logic                     outValid,
  output logic                     outBit,
  input  logic                     outReady
);
  localparam int IDX_W   = $clog2(LONG_CORR);
  localparam int WORD_W  = 2 + IDX_W;
  localparam int SHORT_W = 2 + $clog2(SHORT_CORR);

  stepStrobes_t     strobes;
  logic [IDX_W-1:0] idxCnt;

  cck_pick_ctrl #(
    .SHORT_CORR(SHORT_CORR), .LONG_CORR(LONG_CORR),
    .IDX_W(IDX_W), .SHORT_W(SHORT_W), .WORD_W(WORD_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .longMode(longMode), .inValid(inValid),
    .inLast(inLast), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .idxCnt(idxCnt), .strobes(strobes)
  );

  cck_pick_dp #(
    .DATA_W(DATA_W), .SHORT_CORR(SHORT_CORR), .LONG_CORR(LONG_CORR),
    .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .longMode(longMode), .strobes(strobes),
    .idxCnt(idxCnt), .inI(inI), .inQ(inQ), .seedValid(seedValid),
    .seedBit(seedBit), .outBit(outBit)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBit))); // R9
endmodule

// File: tb/sim_cck_pick_top.sv
module sim_cck_pick_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic longMode = 1'b0, inValid = 1'b0, inLast = 1'b0;
  logic signed [11:0] inI = '0, inQ = '0;
  logic inReady, seedValid = 1'b0, seedBit = 1'b0;
  logic outValid, outBit, outReady = 1'b0;

  always #2.5 clk = ~clk;

  cck_pick_top u0 (
    .clk(clk), .rstN(rstN), .longMode(longMode), .inValid(inValid),
    .inLast(inLast), .inI(inI), .inQ(inQ), .inReady(inReady),
    .seedValid(seedValid), .seedBit(seedBit), .outValid(outValid),
    .outBit(outBit), .outReady(outReady)
  );

  int checks = 0, errors = 0, refQ = 0, rng = 7, stallCnt = 0;
  bit done = 1'b0;
  logic signed [11:0] iv[64], qv[64];

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic logic signed [11:0] rnd();
    rng = rng * 1103515245 + 12345;
    return rng[27:16];
  endfunction

  // reference decision over n pairs; returns word and winner quadrant
  task automatic model(input int n, input bit lng, output int word, output int quad);
    int best = -1, idx = 0, q = 0;
    for (int k = 0; k < n; k++) begin
      int mi = (iv[k] < 0) ? -int'(iv[k]) : int'(iv[k]);
      int mq = (qv[k] < 0) ? -int'(qv[k]) : int'(qv[k]);
      if (mi > best) begin best = mi; idx = k; q = (iv[k] < 0) ? 2 : 0; end
      if (mq > best) begin best = mq; idx = k; q = (qv[k] < 0) ? 3 : 1; end
    end
    quad = q;
    word = ((lng ? idx : (idx & 3)) << 2) | ((q - refQ) & 3);
  endtask

  // send one symbol, drain it with stalls, compare; seedAt>=0 pulses seed with last pair
  task automatic runSym(input int n, input bit lng, input bit useLast,
                        input int seedAt, input bit junk, input string tag);
    int exp, quad, got = 0, nb, cnt = 0;
    nb = lng ? 8 : 4;
    model(n, lng, exp, quad);
    longMode = lng;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b1; inI = iv[k]; inQ = qv[k];
      inLast = useLast && (k == n - 1);
      seedValid = (seedAt >= 0) && (k == n - 1);
      seedBit = (seedAt == 1);
    end
    @(negedge clk);
    seedValid = 1'b0;
    inValid = junk; inLast = junk; inI = 12'sd2047; inQ = -12'sd2048;
    refQ = (seedAt >= 0) ? 2 * seedAt : quad;
    while (cnt < nb) begin
      stallCnt++;
      outReady = (stallCnt % 3) != 1;
      if (!outValid || inReady) chk(1'b0, "R10 busy while pending", inReady, 0);
      if (outValid && outReady) begin got |= int'(outBit) << cnt; cnt++; end
      @(negedge clk);
    end
    outReady = 1'b0; inValid = 1'b0; inLast = 1'b0;
    chk(got == exp, tag, got, exp);
    chk(!outValid && inReady, "R8 drain complete", {outValid, inReady}, 1);
  endtask

  task automatic seedOnly(input bit b);
    @(negedge clk); seedValid = 1'b1; seedBit = b;
    @(negedge clk); seedValid = 1'b0;
    refQ = 2 * b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!outValid, "R1 outValid after reset", outValid, 0);
    chk(inReady, "R1 inReady after reset", inReady, 1);
    rstN = 1'b1;
    // R1: reference 0 -> a quadrature-positive winner gives phase 1
    for (int k = 0; k < 4; k++) begin iv[k] = 12'sd1; qv[k] = 12'sd1; end
    qv[2] = 12'sd500;
    runSym(4, 1'b0, 1'b1, -1, 1'b0, "R1 R4 reset reference");
    // R2 R5 R7 sweep in short mode
    seedOnly(1'b0);
    for (int s = 0; s < 60; s++) begin
      for (int k = 0; k < 4; k++) begin iv[k] = rnd(); qv[k] = rnd(); end
      runSym(4, 1'b0, 1'b1, -1, s[0], "R2 R5 short sweep");
    end
    // R3 ties: all equal magnitude, I over Q at same index
    for (int k = 0; k < 4; k++) begin iv[k] = -12'sd100; qv[k] = 12'sd100; end
    runSym(4, 1'b0, 1'b1, -1, 1'b0, "R3 tie index0 in-phase");
    for (int k = 0; k < 4; k++) begin iv[k] = 12'sd3; qv[k] = 12'sd3; end
    qv[1] = -12'sd900; iv[3] = 12'sd900;
    runSym(4, 1'b0, 1'b1, -1, 1'b0, "R3 tie lowest index");
    // R2 extreme negative value
    for (int k = 0; k < 4; k++) begin iv[k] = 12'sd0; qv[k] = 12'sd0; end
    iv[0] = 12'sd2047; qv[3] = -12'sd2048;
    runSym(4, 1'b0, 1'b1, -1, 1'b0, "R2 R4 full-scale negative");
    // R6 seed with bit 1, then seed coinciding with final pair
    seedOnly(1'b1);
    for (int k = 0; k < 4; k++) begin iv[k] = 12'sd10; qv[k] = 12'sd0; end
    runSym(4, 1'b0, 1'b1, -1, 1'b0, "R6 seed bit one");
    for (int k = 0; k < 4; k++) begin iv[k] = 12'sd0; qv[k] = 12'sd40; end
    runSym(4, 1'b0, 1'b1, 0, 1'b0, "R6 seed same cycle old ref");
    for (int k = 0; k < 4; k++) begin iv[k] = -12'sd0; qv[k] = -12'sd40; end
    runSym(4, 1'b0, 1'b1, -1, 1'b0, "R6 seed applied next symbol");
    // R11 close without inLast, then R10 junk ignored
    for (int k = 0; k < 4; k++) begin iv[k] = rnd(); qv[k] = rnd(); end
    runSym(4, 1'b0, 1'b0, -1, 1'b1, "R11 close at final index");
    for (int k = 0; k < 4; k++) begin iv[k] = rnd(); qv[k] = rnd(); end
    runSym(4, 1'b0, 1'b1, -1, 1'b0, "R10 junk ignored restart index0");
    // short symbol via early inLast
    for (int k = 0; k < 2; k++) begin iv[k] = rnd(); qv[k] = rnd(); end
    runSym(2, 1'b0, 1'b1, -1, 1'b0, "R11 early last");
    // long mode
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 64; k++) begin iv[k] = rnd() >>> 2; qv[k] = rnd() >>> 2; end
      iv[(s * 17 + 5) % 64] = (s[0]) ? -12'sd1900 : 12'sd1900;
      runSym(64, 1'b1, s != 3, -1, 1'b1, "R7 R8 long mode word");
    end
    for (int k = 0; k < 64; k++) begin iv[k] = rnd(); qv[k] = rnd(); end
    runSym(64, 1'b1, 1'b1, -1, 1'b0, "R9 stalled long word");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule